// File: doc/BRIEF.md
# Single-Bus Datapath with Selectable ALU Operands

This block is a 16-bit datapath built around one shared data bus. A general-purpose register, two address pointers and an external data port can each place a value on the bus. The general-purpose register, both pointers and an instruction register can each capture the bus on a clock edge. Any value can therefore move from one bus-capable device to another in a single clock cycle. The instruction register only loads from the bus, and the ALU never drives it.

The ALU has an A and a B operand port. Each port picks one of two sources on its own select line. A 5-bit control word acts on the ALU with no decode stage. Either pointer can take the ALU result in place of the bus value, so a jump target can be computed and written back in the same cycle. A carry flag records the adder's carry-out and can be cleared on its own. Every register shows its contents at all times on a monitor output.

The sequencer that drives the enables is outside this block. A second driver on the bus is treated as an error: the block raises a contention flag and forces the bus to zero for that cycle.

Top module: `dp_single_bus`

## Requirements
- R1: While rst_ni is low, the general-purpose register, both pointers, the instruction register and the carry flag are all zero.
- R2: Drive enables are active low, with bit 0 for the general-purpose register, bit 1 for pointer 0, bit 2 for pointer 1 and bit 3 for the external port. When exactly one enable is low, bus_o carries that source's value in the same cycle. When none is low, bus_o is zero.
- R3: When two or more drive enables are low in the same cycle, contention_o is 1 and bus_o is zero. Otherwise contention_o is 0.
- R4: Load enables are active low, with bit 0 for the general-purpose register, bit 1 for pointer 0, bit 2 for pointer 1 and bit 3 for the instruction register. A device whose load enable is low captures bus_o at the rising clock edge. A device whose load enable is high keeps its value.
- R5: When the write-back select bit of a pointer is 1 (bit 0 for pointer 0, bit 1 for pointer 1), that pointer loads alu_res_o instead of the bus.
- R6: Operand A is pointer 0 when alu_a_sel_i is 1 and the general-purpose register when it is 0. Operand B is bus_o when alu_b_sel_i is 1 and pointer 1 when it is 0.
- R7: The ALU control word works as follows. Bits [1:0] pick the function: 00 add, 01 xor, 10 and, 11 or. Bit 2 inverts operand B before the function is applied. The adder carry-in is bit 4 OR (bit 3 AND carry flag). alu_res_o is combinational.
- R8: When carry_ld_ni is low, the carry flag captures the carry-out of A + B' + carry-in at the clock edge, whatever function is selected.
- R9: When carry_clr_i is high, the carry flag becomes 0 at the next edge. This takes priority over a carry load in the same cycle.
- R10: The monitor outputs always show the register contents, whatever the drive enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drive_en_ni | input | 4 | Bus drive enables, active low (gpr, ptr0, ptr1, ext) |
| load_en_ni | input | 4 | Load enables, active low (gpr, ptr0, ptr1, ir) |
| ext_data_i | input | 16 | External device value driven onto the bus |
| ptr_wb_alu_i | input | 2 | Per-pointer select: load from the ALU instead of the bus |
| alu_a_sel_i | input | 1 | Operand A source: 0 gpr, 1 ptr0 |
| alu_b_sel_i | input | 1 | Operand B source: 0 ptr1, 1 bus |
| alu_ctrl_i | input | 5 | ALU control word |
| carry_ld_ni | input | 1 | Carry flag load enable, active low |
| carry_clr_i | input | 1 | Carry flag clear |
| bus_o | output | 16 | Data bus value |
| contention_o | output | 1 | More than one bus driver is enabled |
| alu_res_o | output | 16 | ALU result |
| carry_o | output | 1 | Carry flag |
| gpr_mon_o | output | 16 | General-purpose register monitor |
| ptr0_mon_o | output | 16 | Pointer 0 monitor |
| ptr1_mon_o | output | 16 | Pointer 1 monitor |
| ir_mon_o | output | 16 | Instruction register monitor |

## Verification
Two pairs of functions can meet in one cycle. In the first, a bus contention can coincide with loads: the bench sweeps every drive-enable pattern while the instruction register loads, and checks that overlapping drivers leave a zero in it. In the second, a carry clear can coincide with a carry load: both are asserted on a cycle whose adder carry-out is 1, and the flag must read 0 afterwards. In both cases the expected values come from an arithmetic model in the bench.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int unsigned N_DRV = 4;
  localparam int unsigned N_LD  = 4;
  localparam int unsigned CTRL_W = 5;

  // drive enable bit positions
  localparam int unsigned DRV_GPR = 0;
  localparam int unsigned DRV_P0  = 1;
  localparam int unsigned DRV_P1  = 2;
  localparam int unsigned DRV_EXT = 3;

  // load enable bit positions
  localparam int unsigned LD_GPR = 0;
  localparam int unsigned LD_P0  = 1;
  localparam int unsigned LD_P1  = 2;
  localparam int unsigned LD_IR  = 3;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_XOR = 2'b01,
    FN_AND = 2'b10,
    FN_OR  = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/dp_bus_arbiter.sv
module dp_bus_arbiter #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 16
) (
  input  logic [N-1:0][W-1:0] src_i,
  input  logic [N-1:0]        drv_ni,
  output logic [W-1:0]        bus_o,
  output logic                contention_o
);
  logic [N-1:0] drv;
  logic [W-1:0] merged;
  logic [$clog2(N+1)-1:0] n_act;

  assign drv = ~drv_ni;

  always_comb begin
    merged = '0;
    n_act  = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (drv[i]) begin
        merged = merged | src_i[i];
        n_act  = n_act + 1'b1;
      end
    end
  end

  assign contention_o = (n_act > 1);
  assign bus_o        = contention_o ? '0 : merged;
endmodule

// File: rtl/dp_reg.sv
module dp_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (!ld_ni) q_o <= d_i;
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]              a_i,
  input  logic [W-1:0]              b_i,
  input  logic [dp_pkg::CTRL_W-1:0] ctrl_i,
  input  logic                      carry_i,
  output logic [W-1:0]              res_o,
  output logic                      cout_o
);
  import dp_pkg::*;

  logic [W-1:0] bx;
  logic         cin;
  logic [W:0]   sum;
  alu_fn_e      fn;

  assign bx  = ctrl_i[2] ? ~b_i : b_i;
  assign cin = ctrl_i[4] | (ctrl_i[3] & carry_i);
  assign sum = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, cin};
  assign fn  = alu_fn_e'(ctrl_i[1:0]);
  assign cout_o = sum[W];

  always_comb begin
    unique case (fn)
      FN_ADD:  res_o = sum[W-1:0];
      FN_XOR:  res_o = a_i ^ bx;
      FN_AND:  res_o = a_i & bx;
      default: res_o = a_i | bx;
    endcase
  end
endmodule

// File: rtl/dp_single_bus.sv
module dp_single_bus #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [dp_pkg::N_DRV-1:0]   drive_en_ni,
  input  logic [dp_pkg::N_LD-1:0]    load_en_ni,
  input  logic [DATA_W-1:0]          ext_data_i,
  input  logic [1:0]                 ptr_wb_alu_i,
  input  logic                       alu_a_sel_i,
  input  logic                       alu_b_sel_i,
  input  logic [dp_pkg::CTRL_W-1:0]  alu_ctrl_i,
  input  logic                       carry_ld_ni,
  input  logic                       carry_clr_i,
  output logic [DATA_W-1:0]          bus_o,
  output logic                       contention_o,
  output logic [DATA_W-1:0]          alu_res_o,
  output logic                       carry_o,
  output logic [DATA_W-1:0]          gpr_mon_o,
  output logic [DATA_W-1:0]          ptr0_mon_o,
  output logic [DATA_W-1:0]          ptr1_mon_o,
  output logic [DATA_W-1:0]          ir_mon_o
);
  import dp_pkg::*;

  localparam int unsigned N_PTR = 2;

  logic [N_DRV-1:0][DATA_W-1:0] src;
  logic [N_LD-1:0][DATA_W-1:0]  reg_q;
  logic [N_LD-1:0][DATA_W-1:0]  reg_d;
  logic [DATA_W-1:0]            op_a, op_b;
  logic                         alu_cout;
  logic                         carry_q;

  assign src[DRV_GPR] = reg_q[LD_GPR];
  assign src[DRV_P0]  = reg_q[LD_P0];
  assign src[DRV_P1]  = reg_q[LD_P1];
  assign src[DRV_EXT] = ext_data_i;

  dp_bus_arbiter #(.N(N_DRV), .W(DATA_W)) i_arb (
    .src_i        (src),
    .drv_ni       (drive_en_ni),
    .bus_o        (bus_o),
    .contention_o (contention_o)
  );

  assign op_a = alu_a_sel_i ? reg_q[LD_P0] : reg_q[LD_GPR];
  assign op_b = alu_b_sel_i ? bus_o        : reg_q[LD_P1];

  dp_alu #(.W(DATA_W)) i_alu (
    .a_i     (op_a),
    .b_i     (op_b),
    .ctrl_i  (alu_ctrl_i),
    .carry_i (carry_q),
    .res_o   (alu_res_o),
    .cout_o  (alu_cout)
  );

  // pointers may take the ALU result for in-place jump targets
  assign reg_d[LD_GPR] = bus_o;
  assign reg_d[LD_IR]  = bus_o;
  for (genvar p = 0; p < int'(N_PTR); p++) begin : g_ptr_src
    assign reg_d[LD_P0+p] = ptr_wb_alu_i[p] ? alu_res_o : bus_o;
  end

  for (genvar r = 0; r < int'(N_LD); r++) begin : g_reg
    dp_reg #(.W(DATA_W)) i_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_ni  (load_en_ni[r]),
      .d_i    (reg_d[r]),
      .q_o    (reg_q[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           carry_q <= 1'b0;
    else if (carry_clr_i)  carry_q <= 1'b0;
    else if (!carry_ld_ni) carry_q <= alu_cout;
  end

  assign carry_o    = carry_q;
  assign gpr_mon_o  = reg_q[LD_GPR];
  assign ptr0_mon_o = reg_q[LD_P0];
  assign ptr1_mon_o = reg_q[LD_P1];
  assign ir_mon_o   = reg_q[LD_IR];
endmodule

// File: rtl/dp_single_bus_chk.sv
module dp_single_bus_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        drive_en_ni,
  input logic [3:0]        load_en_ni,
  input logic              carry_clr_i,
  input logic [DATA_W-1:0] bus_o,
  input logic              contention_o,
  input logic              carry_o,
  input logic [DATA_W-1:0] gpr_mon_o,
  input logic [DATA_W-1:0] ir_mon_o
);
  // R3
  contention_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(~drive_en_ni) > 1) |-> (contention_o && bus_o == '0));

  // R2
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_ni == 4'hF) |-> (bus_o == '0 && !contention_o));

  // R2
  gpr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_ni == 4'b1110) |-> (bus_o == gpr_mon_o));

  // R4
  gpr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_ni[0] |=> $stable(gpr_mon_o));

  // R4
  ir_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_en_ni[3] |=> (ir_mon_o == $past(bus_o)));

  // R9
  carry_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_clr_i |=> !carry_o);
endmodule

bind dp_single_bus dp_single_bus_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .drive_en_ni  (drive_en_ni),
  .load_en_ni   (load_en_ni),
  .carry_clr_i  (carry_clr_i),
  .bus_o        (bus_o),
  .contention_o (contention_o),
  .carry_o      (carry_o),
  .gpr_mon_o    (gpr_mon_o),
  .ir_mon_o     (ir_mon_o)
);

// File: tb/test_dp_single_bus.sv
module test_dp_single_bus;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   drive_en_ni = 4'hF;
  logic [3:0]   load_en_ni = 4'hF;
  logic [W-1:0] ext_data_i = '0;
  logic [1:0]   ptr_wb_alu_i = '0;
  logic         alu_a_sel_i = 1'b0;
  logic         alu_b_sel_i = 1'b0;
  logic [4:0]   alu_ctrl_i = '0;
  logic         carry_ld_ni = 1'b1;
  logic         carry_clr_i = 1'b0;
  logic [W-1:0] bus_o, alu_res_o, gpr_mon_o, ptr0_mon_o, ptr1_mon_o, ir_mon_o;
  logic         contention_o, carry_o;

  always #10 clk = ~clk;

  dp_single_bus #(.DATA_W(W)) i_dp_single_bus (
    .clk_i(clk), .rst_ni(rst_ni), .drive_en_ni(drive_en_ni), .load_en_ni(load_en_ni),
    .ext_data_i(ext_data_i), .ptr_wb_alu_i(ptr_wb_alu_i), .alu_a_sel_i(alu_a_sel_i),
    .alu_b_sel_i(alu_b_sel_i), .alu_ctrl_i(alu_ctrl_i), .carry_ld_ni(carry_ld_ni),
    .carry_clr_i(carry_clr_i), .bus_o(bus_o), .contention_o(contention_o),
    .alu_res_o(alu_res_o), .carry_o(carry_o), .gpr_mon_o(gpr_mon_o),
    .ptr0_mon_o(ptr0_mon_o), .ptr1_mon_o(ptr1_mon_o), .ir_mon_o(ir_mon_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [W-1:0] m_gpr = '0, m_p0 = '0, m_p1 = '0, m_ir = '0;
  logic         m_c = 1'b0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: apply, check combinational results, clock, check state
  task automatic step(input logic [3:0] drv, input logic [3:0] ld, input logic [1:0] wb,
                      input logic asel, input logic bsel, input logic [4:0] ctl,
                      input logic fld_n, input logic clr, input logic [W-1:0] ext);
    logic [W-1:0] e_bus, a, b, bx, e_res;
    logic [W:0]   s;
    logic         e_cont, cin;
    int           nd;
    @(negedge clk);
    drive_en_ni = drv; load_en_ni = ld; ptr_wb_alu_i = wb; alu_a_sel_i = asel;
    alu_b_sel_i = bsel; alu_ctrl_i = ctl; carry_ld_ni = fld_n; carry_clr_i = clr;
    ext_data_i = ext;
    #2;
    nd = 0; e_bus = '0;
    if (!drv[0]) begin nd++; e_bus = m_gpr; end
    if (!drv[1]) begin nd++; e_bus = m_p0; end
    if (!drv[2]) begin nd++; e_bus = m_p1; end
    if (!drv[3]) begin nd++; e_bus = ext; end
    e_cont = (nd > 1);
    if (e_cont) e_bus = '0;
    a  = asel ? m_p0 : m_gpr;
    b  = bsel ? e_bus : m_p1;
    bx = ctl[2] ? ~b : b;
    cin = ctl[4] | (ctl[3] & m_c);
    s = {1'b0, a} + {1'b0, bx} + (W+1)'(cin);
    case (ctl[1:0])
      2'b00: e_res = s[W-1:0];
      2'b01: e_res = a ^ bx;
      2'b10: e_res = a & bx;
      default: e_res = a | bx;
    endcase
    chk("R2 bus", bus_o, e_bus);
    chk("R3 contention", {15'd0, contention_o}, {15'd0, e_cont});
    chk("R7 R6 alu result", alu_res_o, e_res);
    if (!ld[0]) m_gpr = e_bus;
    if (!ld[1]) m_p0 = wb[0] ? e_res : e_bus;
    if (!ld[2]) m_p1 = wb[1] ? e_res : e_bus;
    if (!ld[3]) m_ir = e_bus;
    if (clr) m_c = 1'b0;
    else if (!fld_n) m_c = s[W];
    @(posedge clk);
    #2;
    chk("R4 R10 gpr", gpr_mon_o, m_gpr);
    chk("R4 R5 ptr0", ptr0_mon_o, m_p0);
    chk("R4 R5 ptr1", ptr1_mon_o, m_p1);
    chk("R4 ir", ir_mon_o, m_ir);
    chk("R8 R9 carry", {15'd0, carry_o}, {15'd0, m_c});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (2) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 gpr", gpr_mon_o, '0);
    chk("R1 ptr0", ptr0_mon_o, '0);
    chk("R1 ptr1", ptr1_mon_o, '0);
    chk("R1 ir", ir_mon_o, '0);
    chk("R1 carry", {15'd0, carry_o}, '0);
    @(negedge clk) rst_ni = 1'b1;

    // seed registers through the external port
    step(4'b0111, 4'b1110, 2'b00, 0, 0, 5'd0, 1, 0, 16'h1234);
    step(4'b0111, 4'b1101, 2'b00, 0, 0, 5'd0, 1, 0, 16'hA5C3);
    step(4'b0111, 4'b1011, 2'b00, 0, 0, 5'd0, 1, 0, 16'h0F0F);

    // R2 R3: every drive pattern, IR captures the bus
    for (int d = 0; d < 16; d++)
      step(d[3:0], 4'b0111, 2'b00, 0, 0, 5'd0, 1, 0, 16'h8000 | 16'(d * 7));

    // R4: every load mask, one-cycle copies from each source
    for (int l = 0; l < 16; l++) begin
      step(4'b0111, l[3:0], 2'b00, 0, 0, 5'd0, 1, 0, 16'(16'h1111 * l + 3));
      step(4'b1110, 4'b1011, 2'b00, 0, 0, 5'd0, 1, 0, '0);  // gpr -> ptr1
      step(4'b1101, 4'b0111, 2'b00, 0, 0, 5'd0, 1, 0, '0);  // ptr0 -> ir
    end

    // R6 R7 R8: all control words, both selects, both carry states
    for (int c = 0; c < 32; c++)
      for (int s = 0; s < 4; s++) begin
        step(4'b0111, 4'b1110, 2'b00, 0, 0, 5'd0, 1, 0, 16'(16'hFFF0 + c * 3 + s));
        step(4'b0111, 4'b1101, 2'b00, 0, 0, 5'd0, 1, 0, 16'(16'h7FF0 ^ (c << 4)));
        step(4'b0111, 4'b1111, 2'b00, s[0], s[1], c[4:0], 0, 0, 16'(16'h9000 + c));
      end

    // R5: write-back of the ALU result into each pointer
    step(4'b1111, 4'b1101, 2'b01, 1, 0, 5'b00000, 1, 0, '0);
    step(4'b0111, 4'b1011, 2'b10, 0, 1, 5'b10100, 1, 0, 16'h0042);
    step(4'b0111, 4'b1001, 2'b11, 1, 1, 5'b00011, 1, 0, 16'hF00D);

    // R9: clear and load together with carry-out 1
    step(4'b0111, 4'b1110, 2'b00, 0, 0, 5'd0, 1, 0, 16'hFFFF);
    step(4'b0111, 4'b1111, 2'b00, 0, 1, 5'b10000, 0, 0, 16'h0001);
    step(4'b0111, 4'b1111, 2'b00, 0, 1, 5'b10000, 0, 1, 16'h0001);
    step(4'b1111, 4'b1111, 2'b00, 0, 0, 5'd0, 1, 0, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule